// File: doc/BRIEF.md
# Link Request Receiver and Bus Access Tracker

This block sits on the physical-layer side of a serial bus node. It turns the link layer's one-wire request stream back into request frames. It keeps at most one bus-access request waiting. It decides, from the state of the bus, whether that request is taken, ignored, cancelled or granted. The waiting request goes out to the bus arbiter. Register read and write frames are decoded into one-cycle strobes. The link learns the outcome through a grant level and a one-cycle lost pulse.

A frame begins with a start bit of 1. Then come a 3-bit request code, the register address, the data byte (write frames only) and a stop bit of 0. Every field is sent most significant bit first. With the default parameters a frame is 9 cycles long, or 17 cycles for a write. Shorter bursts cannot form a frame. The line must be 0 between frames. The request codes are:

- 0: release
- 1: acknowledge (immediate)
- 2: isochronous
- 3: priority
- 4: fair
- 5: register read
- 6: register write
- 7: reserved

Top module: `link_req_handler`

## Requirements
- R1: A frame is decoded in the cycle its stop bit is sampled. A write frame (code 6) pulses `reg_wr` for one cycle with its address and data. A read frame (code 5) pulses `reg_rd` with its address. Both are accepted whatever the bus-access state.
- R2: A frame whose stop bit is 1 is discarded completely.
- R3: A fair (4) or priority (3) frame is ignored if `rx_active` is sampled high in any of its bit cycles. Acknowledge (1) and isochronous (2) frames are accepted regardless of `rx_active`.
- R4: While a request is waiting or `grant` is high, new bus-access frames (codes 1 to 4) are ignored and `req_type` holds. Code 7 is never taken.
- R5: A rising edge of `rx_active` while a fair, priority or isochronous request waits gives a one-cycle `lost` pulse in the next cycle and drops the request.
- R6: `bus_won` while a fair, priority or isochronous request waits raises `grant` in the next cycle and clears `req_valid`. `bus_won` with nothing waiting has no effect.
- R7: A waiting acknowledge request is not lost when a packet arrives. `grant` rises in the cycle after `rx_end`.
- R8: A release frame (code 0) clears any waiting request and drops `grant`, without a `lost` pulse.
- R9: A grant won by an isochronous request drops after IDLE_CYC consecutive cycles with both `rx_active` and `tx_active` low (default 4). Any cycle with either high restarts the count.
- R10: `tx_done` drops `grant` in the next cycle.
- R11: After reset, `req_valid`, `grant`, `lost`, `reg_rd` and `reg_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq | input | 1 | Serial request line from the link |
| rx_active | input | 1 | Incoming packet on the bus |
| rx_end | input | 1 | One-cycle end of received packet |
| bus_won | input | 1 | Arbitration won |
| tx_active | input | 1 | Link is transmitting |
| tx_done | input | 1 | One-cycle end of transmitted packet |
| req_valid | output | 1 | A bus-access request is waiting |
| req_type | output | 3 | Code of the waiting request |
| grant | output | 1 | Bus granted to the link |
| lost | output | 1 | One-cycle request lost pulse |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Register write data |

## Verification
The bench sweeps every request code, each with and without bus reception during the frame. A design that only looked at `rx_active` at the stop bit, or that applied the reception rule to acknowledge and isochronous requests, takes or drops the wrong requests. The isochronous timeout is checked one cycle before and one cycle at its limit, and again after a busy cycle that must restart the count. An off-by-one counter, or one that is never restarted, moves the grant drop by a cycle. The bench also checks the following:

- An acknowledge request survives packet arrival. A design that treated it like the other types would pulse `lost` instead of granting at `rx_end`.
- A release frame ends a grant quietly, with no `lost` pulse.
- A write frame sweep covers all addresses, so a shifted field boundary shows up.

// File: rtl/link_req_handler.sv
module link_req_handler #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int IDLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lreq,
  input  logic              rx_active,
  input  logic              rx_end,
  input  logic              bus_won,
  input  logic              tx_active,
  input  logic              tx_done,
  output logic              req_valid,
  output logic [2:0]        req_type,
  output logic              grant,
  output logic              lost,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata
);

  localparam int SHORT_LEN = 1 + 3 + ADDR_W + 1;
  localparam int LONG_LEN  = SHORT_LEN + DATA_W;
  localparam int SH_W      = ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(LONG_LEN);
  localparam int IC_W      = $clog2(IDLE_CYC + 1);

  localparam logic [2:0] C_REL  = 3'd0;
  localparam logic [2:0] C_IMM  = 3'd1;
  localparam logic [2:0] C_ISO  = 3'd2;
  localparam logic [2:0] C_PRI  = 3'd3;
  localparam logic [2:0] C_FAIR = 3'd4;
  localparam logic [2:0] C_RD   = 3'd5;
  localparam logic [2:0] C_WR   = 3'd6;

  logic             busy, rx_seen, rx_q, gnt_iso;
  logic [CNT_W-1:0] idx;
  logic [2:0]       ftype;
  logic [SH_W-1:0]  sh;
  logic [IC_W-1:0]  idle_cnt;

  wire is_wr     = (ftype == C_WR);
  wire last      = busy && (idx == (is_wr ? CNT_W'(LONG_LEN - 2) : CNT_W'(SHORT_LEN - 2)));
  wire frame_ok  = last && !lreq;
  wire rx_any    = rx_seen || rx_active;
  wire rx_rise   = rx_active && !rx_q;
  wire is_bus    = (ftype == C_IMM) || (ftype == C_ISO) || (ftype == C_PRI) || (ftype == C_FAIR);
  wire rx_block  = rx_any && ((ftype == C_PRI) || (ftype == C_FAIR));
  wire take_req  = frame_ok && is_bus && !rx_block;
  wire bus_idle  = !rx_active && !tx_active;

  // serial frame capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      ftype   <= '0;
      sh      <= '0;
      rx_seen <= 1'b0;
    end else if (!busy) begin
      if (lreq) begin
        busy    <= 1'b1;
        idx     <= '0;
        ftype   <= '0;
        rx_seen <= rx_active;
      end
    end else begin
      rx_seen <= rx_any;
      if (last) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
        if (idx < CNT_W'(3)) ftype <= {ftype[1:0], lreq};
        else                 sh    <= {sh[SH_W-2:0], lreq};
      end
    end
  end

  // register access strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_rd <= frame_ok && (ftype == C_RD);
      reg_wr <= frame_ok && is_wr;
      if (frame_ok && is_wr) begin
        reg_addr  <= sh[SH_W-1:DATA_W];
        reg_wdata <= sh[DATA_W-1:0];
      end else if (frame_ok && (ftype == C_RD)) begin
        reg_addr  <= sh[ADDR_W-1:0];
      end
    end
  end

  // pending request and grant tracking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_type  <= '0;
      grant     <= 1'b0;
      gnt_iso   <= 1'b0;
      lost      <= 1'b0;
      rx_q      <= 1'b0;
      idle_cnt  <= '0;
    end else begin
      rx_q <= rx_active;
      lost <= 1'b0;
      if (frame_ok && ftype == C_REL) begin
        req_valid <= 1'b0;
        grant     <= 1'b0;
        gnt_iso   <= 1'b0;
      end else if (req_valid) begin
        if (req_type == C_IMM) begin
          if (rx_end) begin
            grant     <= 1'b1;
            gnt_iso   <= 1'b0;
            req_valid <= 1'b0;
          end
        end else if (rx_rise) begin
          lost      <= 1'b1;
          req_valid <= 1'b0;
        end else if (bus_won) begin
          grant     <= 1'b1;
          gnt_iso   <= (req_type == C_ISO);
          idle_cnt  <= '0;
          req_valid <= 1'b0;
        end
      end else if (grant) begin
        if (tx_done) begin
          grant <= 1'b0;
        end else if (gnt_iso) begin
          if (!bus_idle)                           idle_cnt <= '0;
          else if (idle_cnt == IC_W'(IDLE_CYC - 1)) grant   <= 1'b0;
          else                                     idle_cnt <= idle_cnt + 1'b1;
        end
      end else if (take_req) begin
        req_valid <= 1'b1;
        req_type  <= ftype;
      end
    end
  end

  p_lost_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> !lost);
  p_lost_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> !req_valid && $past(req_valid));
  p_hold_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid)) |-> $stable(req_type));
  p_grant_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> ($past(bus_won) || $past(rx_end)));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && req_valid));
  p_idle_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt < IC_W'(IDLE_CYC));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && ftype == C_REL) |=> (!grant && !req_valid && !lost));
  p_bad_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (last && lreq) |=> (!reg_rd && !reg_wr));

endmodule

// File: tb/link_req_handler_tb.sv
module link_req_handler_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lreq = 0, rx_active = 0, rx_end = 0, bus_won = 0, tx_active = 0, tx_done = 0;
  logic req_valid, grant, lost, reg_rd, reg_wr;
  logic [2:0] req_type;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  link_req_handler u_dut (.clk, .rst_n, .lreq, .rx_active, .rx_end, .bus_won,
    .tx_active, .tx_done, .req_valid, .req_type, .grant, .lost, .reg_rd,
    .reg_wr, .reg_addr, .reg_wdata);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] t, input logic [3:0] a, input logic [7:0] d,
                      input bit stop, input bit rxd);
    logic [16:0] bits;
    int n;
    bits = {1'b1, t, a, d, stop};
    n = (t == 3'd6) ? 17 : 9;
    if (n == 9) bits = {bits[16:9], stop, 8'h00};
    for (int i = 0; i < n; i++) begin
      lreq = bits[16 - i];
      rx_active = rxd;
      @(negedge clk);
    end
    lreq = 0;
    rx_active = 0;
  endtask

  task automatic release_all();
    send(3'd0, 4'd0, 8'd0, 0, 0);
    @(negedge clk);
  endtask

  task automatic pulse_won();
    bus_won = 1;
    @(negedge clk);
    bus_won = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!req_valid && !grant && !lost && !reg_rd && !reg_wr, "R11 reset",
        {req_valid, grant, lost, reg_rd, reg_wr}, 0);

    // R1 R3 sweep of codes with and without reception
    for (int t = 0; t < 8; t++) begin
      for (int r = 0; r < 2; r++) begin
        bit exp_v;
        exp_v = (t == 1) || (t == 2) || ((t == 3 || t == 4) && r == 0);
        send(3'(t), 4'(t), 8'h00, 0, r[0]);
        chk(req_valid == exp_v, "R3 accept", req_valid, exp_v);
        if (exp_v) chk(req_type == 3'(t), "R3 type", req_type, t);
        chk(reg_rd == (t == 5), "R1 read strobe", reg_rd, t == 5);
        chk(reg_wr == (t == 6), "R1 write strobe", reg_wr, t == 6);
        if (t == 7) chk(!req_valid, "R4 reserved", req_valid, 0);
        release_all();
        chk(!req_valid, "R8 release clears", req_valid, 0);
      end
    end

    // R1 register access sweep
    for (int a = 0; a < 16; a++) begin
      logic [7:0] d;
      d = 8'((a * 17) ^ 8'h5A);
      send(3'd6, 4'(a), d, 0, 0);
      chk(reg_wr && reg_addr == 4'(a) && reg_wdata == d, "R1 write fields",
          {reg_addr, reg_wdata}, {a[3:0], d});
      @(negedge clk);
      chk(!reg_wr, "R1 write pulse width", reg_wr, 0);
      send(3'd5, 4'(15 - a), 8'h00, 0, 0);
      chk(reg_rd && reg_addr == 4'(15 - a), "R1 read addr", reg_addr, 15 - a);
    end

    // R2 bad stop bit
    send(3'd4, 4'd0, 8'd0, 1, 0);
    chk(!req_valid, "R2 bad stop fair", req_valid, 0);
    @(negedge clk);
    send(3'd6, 4'd3, 8'hA5, 1, 0);
    chk(!reg_wr, "R2 bad stop write", reg_wr, 0);
    @(negedge clk);

    // R4 ignore while waiting
    send(3'd4, 4'd0, 8'd0, 0, 0);
    send(3'd1, 4'd0, 8'd0, 0, 0);
    chk(req_valid && req_type == 3'd4, "R4 hold over imm", req_type, 4);
    send(3'd2, 4'd0, 8'd0, 0, 0);
    chk(req_valid && req_type == 3'd4, "R4 hold over iso", req_type, 4);
    release_all();

    // R5 lost on arrival
    for (int t = 2; t < 5; t++) begin
      send(3'(t), 4'd0, 8'd0, 0, 0);
      @(negedge clk);
      rx_active = 1;
      @(negedge clk);
      chk(lost && !req_valid, "R5 lost pulse", {lost, req_valid}, 2);
      @(negedge clk);
      chk(!lost, "R5 lost one cycle", lost, 0);
      rx_active = 0;
      @(negedge clk);
    end

    // R7 acknowledge survives arrival and grants at end of packet
    send(3'd1, 4'd0, 8'd0, 0, 0);
    rx_active = 1;
    repeat (3) @(negedge clk);
    chk(!lost && req_valid && !grant, "R7 imm not lost", {lost, req_valid, grant}, 2);
    rx_active = 0;
    rx_end = 1;
    @(negedge clk);
    rx_end = 0;
    chk(grant && !req_valid, "R7 imm grant", grant, 1);
    // R8 release ends grant quietly
    send(3'd0, 4'd0, 8'd0, 0, 1);
    chk(!grant && !lost, "R8 release grant", {grant, lost}, 0);
    @(negedge clk);
    chk(!lost, "R8 no lost after", lost, 0);

    // R6 R10 won for fair and priority
    for (int t = 3; t < 5; t++) begin
      send(3'(t), 4'd0, 8'd0, 0, 0);
      pulse_won();
      chk(grant && !req_valid, "R6 grant", {grant, req_valid}, 2);
      repeat (6) @(negedge clk);
      chk(grant, "R9 no timeout for non-iso", grant, 1);
      tx_done = 1;
      @(negedge clk);
      tx_done = 0;
      chk(!grant, "R10 tx_done", grant, 0);
    end
    pulse_won();
    chk(!grant, "R6 won without request", grant, 0);

    // R9 isochronous idle timeout
    send(3'd2, 4'd0, 8'd0, 0, 0);
    pulse_won();
    chk(grant, "R6 iso grant", grant, 1);
    repeat (3) @(negedge clk);
    chk(grant, "R9 before limit", grant, 1);
    @(negedge clk);
    chk(!grant, "R9 at limit", grant, 0);

    // R9 restart by activity
    send(3'd2, 4'd0, 8'd0, 0, 0);
    pulse_won();
    repeat (2) @(negedge clk);
    tx_active = 1;
    @(negedge clk);
    tx_active = 0;
    repeat (3) @(negedge clk);
    chk(grant, "R9 restarted", grant, 1);
    @(negedge clk);
    chk(!grant, "R9 restart limit", grant, 0);

    // R10 iso transmitted
    send(3'd2, 4'd0, 8'd0, 0, 0);
    pulse_won();
    tx_active = 1;
    repeat (10) @(negedge clk);
    chk(grant, "R9 held while sending", grant, 1);
    tx_active = 0;
    tx_done = 1;
    @(negedge clk);
    tx_done = 0;
    chk(!grant, "R10 iso tx_done", grant, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule